// File: doc/BRIEF.md
# Double-Buffered Parallel Output Stage

This block is the logic-side control for a bank of parallel output channels, eight by default. Channel data moves through two storage stages before it reaches the driven outputs. The first stage is the input buffer. The second is the transmission buffer, which feeds the output register. Two active-low controls, a load strobe and a commit strobe, decide which stage moves. The way a host drives these two pins picks the mode. Tying them together gives transparent direct control. Driving them separately gives synchronous control, where every channel changes on the same commit rising edge, so several devices that share one commit line switch together.

An active-high enable forces every output off while it is low, whatever the other controls do. When the enable returns, the outputs show whatever the output register holds at that moment. All three controls and the data bus pass through two-flop synchronisers, and the block acts only on the synchronised values. A periodic refresh strobe stands in for the transfer to the isolated output side. It rewrites the output register from the transmission buffer, and it is held off while a commit is being staged.

Top module: `par_out_stage`

## Requirements
- R1: With load low and commit high, the input buffer takes the data bus and the outputs do not change.
- R2: With load high and commit low, the transmission buffer takes the input buffer, and the periodic refresh is suppressed, so the outputs do not change however long this state lasts.
- R3: A rising edge of the synchronised commit signal while load is high copies the transmission buffer to all outputs in the same cycle.
- R4: With load and commit both low, each output follows its own data bit (bit i drives channel i).
- R5: With load and commit both high, the outputs keep their value whatever the data bus does, including across refresh periods.
- R6: While the synchronised enable is low, every output is 0, in every control state.
- R7: The asynchronous active-low reset clears the input buffer, the transmission buffer and the output register to all-off.
- R8: When the enable rises, the outputs show the present output-register value, which includes any direct-mode update made while the enable was low.
- R9: A data change in direct mode reaches the outputs after three clock edges: two synchroniser stages and the output register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock on which all controls are sampled |
| rstN | input | 1 | Asynchronous active-low reset |
| dataIn | input | CHANNELS | Channel data bus |
| loadN | input | 1 | Active-low input-buffer load |
| syncN | input | 1 | Active-low commit; its rising edge updates the outputs |
| outEn | input | 1 | Output enable; low forces all outputs off |
| chOut | output | CHANNELS | Channel output drive, 1 = on |

## Verification
The bench holds the transfer state for longer than a refresh period and checks that the old outputs survive. A design that lets the refresh run there would show the staged value before the commit edge. It also raises the enable again after a direct-mode update made while the outputs were forced off, which catches designs that clear the output register on disable or freeze it. A commit issued right after reset must produce all-off, which exposes buffers that reset does not clear. Sampling the outputs two and three edges after a data change pins the pipeline depth and catches a missing or extra synchroniser stage.

// File: rtl/par_out_pkg.sv
package par_out_pkg;
  // Strobes issued by the control to the datapath, one cycle each.
  typedef struct packed {
    logic capture;   // input buffer <- data
    logic transfer;  // transmission buffer <- input buffer
    logic commit;    // output register <- transmission buffer
    logic direct;    // output register and transmission buffer <- data
    logic refresh;   // periodic rewrite of output register
  } strobe_t;
endpackage

// File: rtl/par_out_sync.sv
module par_out_sync #(
  parameter int WIDTH = 1,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stageQ [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < STAGES; i++) stageQ[i] <= RESET_VAL;
    end else begin
      stageQ[0] <= din;
      for (int i = 1; i < STAGES; i++) stageQ[i] <= stageQ[i-1];
    end
  end

  assign dout = stageQ[STAGES-1];
endmodule

// File: rtl/par_out_ctrl.sv
module par_out_ctrl
  import par_out_pkg::*;
#(
  parameter int REFRESH_CYCLES = 64
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    loadS,
  input  logic    syncS,
  output strobe_t strobe
);
  localparam int CNT_W = $clog2(REFRESH_CYCLES);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(REFRESH_CYCLES - 1);

  logic syncPrev;
  logic [CNT_W-1:0] refreshCnt;
  logic refreshTick;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncPrev   <= 1'b1;
      refreshCnt <= '0;
    end else begin
      syncPrev   <= syncS;
      refreshCnt <= (refreshCnt == CNT_LAST) ? '0 : refreshCnt + 1'b1;
    end
  end

  assign refreshTick = (refreshCnt == CNT_LAST);

  always_comb begin
    strobe.capture  = !loadS && syncS;
    strobe.transfer = loadS && !syncS;
    strobe.commit   = loadS && syncS && !syncPrev;
    strobe.direct   = !loadS && !syncS;
    strobe.refresh  = refreshTick && !strobe.transfer && !strobe.direct;
  end

  // R2: refresh never coincides with a staged commit
  p_refresh_held_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.transfer |-> !strobe.refresh);
endmodule

// File: rtl/par_out_datapath.sv
module par_out_datapath
  import par_out_pkg::*;
#(
  parameter int CHANNELS = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  strobe_t             strobe,
  input  logic [CHANNELS-1:0] dataS,
  input  logic                enS,
  output logic [CHANNELS-1:0] chOut
);
  logic [CHANNELS-1:0] inBuf;
  logic [CHANNELS-1:0] txBuf;
  logic [CHANNELS-1:0] outReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inBuf  <= '0;
      txBuf  <= '0;
      outReg <= '0;
    end else begin
      if (strobe.capture) inBuf <= dataS;
      if (strobe.direct) begin
        txBuf  <= dataS;
        outReg <= dataS;
      end else begin
        if (strobe.transfer) txBuf <= inBuf;
        if (strobe.commit || strobe.refresh) outReg <= txBuf;
      end
    end
  end

  assign chOut = enS ? outReg : '0;

  p_capture_keeps_r1: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.capture && !strobe.refresh) |=> $stable(outReg));
  p_transfer_keeps_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.transfer |=> $stable(outReg));
  p_commit_loads_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.commit |=> (outReg == $past(txBuf)));
  p_direct_follows_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.direct |=> (outReg == $past(dataS)));
endmodule

// File: rtl/par_out_stage.sv
module par_out_stage
  import par_out_pkg::*;
#(
  parameter int CHANNELS = 8,
  parameter int REFRESH_CYCLES = 64
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [CHANNELS-1:0] dataIn,
  input  logic                loadN,
  input  logic                syncN,
  input  logic                outEn,
  output logic [CHANNELS-1:0] chOut
);
  logic [2:0] ctrlS;
  logic [CHANNELS-1:0] dataS;
  strobe_t strobe;

  par_out_sync #(.WIDTH(3), .STAGES(2), .RESET_VAL(3'b110)) u_ctrlSync (
    .clk(clk), .rstN(rstN), .din({loadN, syncN, outEn}), .dout(ctrlS));

  par_out_sync #(.WIDTH(CHANNELS), .STAGES(2), .RESET_VAL('0)) u_dataSync (
    .clk(clk), .rstN(rstN), .din(dataIn), .dout(dataS));

  par_out_ctrl #(.REFRESH_CYCLES(REFRESH_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN), .loadS(ctrlS[2]), .syncS(ctrlS[1]), .strobe(strobe));

  par_out_datapath #(.CHANNELS(CHANNELS)) u_datapath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .dataS(dataS), .enS(ctrlS[0]),
    .chOut(chOut));

  // R6: enable seen low at the pin two edges ago forces all outputs off
  p_disabled_off_r6: assert property (@(posedge clk) disable iff (!rstN)
    !$past(outEn, 2) |-> (chOut == '0));
endmodule

// File: tb/test_par_out_stage.sv
module test_par_out_stage;
  localparam int CH = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [CH-1:0] dataIn = '0;
  logic loadN = 1'b1;
  logic syncN = 1'b1;
  logic outEn = 1'b0;
  logic [CH-1:0] chOut;

  int checks = 0;
  int fails = 0;

  always #5 clk = ~clk;

  par_out_stage #(.CHANNELS(CH), .REFRESH_CYCLES(64)) i_par_out_stage (
    .clk(clk), .rstN(rstN), .dataIn(dataIn), .loadN(loadN), .syncN(syncN),
    .outEn(outEn), .chOut(chOut));

  task automatic waitCycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic checkOut(input logic [CH-1:0] exp, input string req);
    checks++;
    if (chOut !== exp) begin
      fails++;
      $display("FAIL %s: chOut=%h expected=%h", req, chOut, exp);
    end
  endtask

  task automatic setCtrl(input logic ld, input logic sy);
    loadN = ld;
    syncN = sy;
  endtask

  task automatic testReset();
    @(negedge clk);
    checkOut(8'h00, "R7 reset");
    rstN = 1'b1;
    outEn = 1'b1;
    waitCycles(4);
    checkOut(8'h00, "R7 idle after reset");
  endtask

  task automatic testDirect();
    setCtrl(1'b0, 1'b0);
    dataIn = 8'h5A;
    waitCycles(4);
    checkOut(8'h5A, "R4 direct");
    dataIn = 8'hA7;
    waitCycles(2);
    checkOut(8'h5A, "R9 not before third edge");
    waitCycles(1);
    checkOut(8'hA7, "R9 third edge");
    dataIn = 8'h5A;
    waitCycles(4);
    checkOut(8'h5A, "R4 direct back");
  endtask

  task automatic testHold();
    setCtrl(1'b1, 1'b1);
    waitCycles(4);
    dataIn = 8'hFF;
    waitCycles(150);
    checkOut(8'h5A, "R5 hold across refresh");
  endtask

  task automatic testSyncPath();
    setCtrl(1'b0, 1'b1);
    dataIn = 8'h3C;
    waitCycles(4);
    checkOut(8'h5A, "R1 capture keeps outputs");
    setCtrl(1'b1, 1'b1);
    dataIn = 8'hC3;
    waitCycles(4);
    setCtrl(1'b1, 1'b0);
    waitCycles(150);
    checkOut(8'h5A, "R2 transfer keeps outputs, refresh held");
    syncN = 1'b1;
    waitCycles(2);
    checkOut(8'h5A, "R3 not yet committed");
    waitCycles(1);
    checkOut(8'h3C, "R3 commit edge");
    waitCycles(150);
    checkOut(8'h3C, "R5 committed value held");
  endtask

  task automatic testEnable();
    outEn = 1'b0;
    waitCycles(2);
    checkOut(8'h00, "R6 disabled");
    setCtrl(1'b0, 1'b0);
    dataIn = 8'h0F;
    waitCycles(6);
    checkOut(8'h00, "R6 disabled in direct mode");
    setCtrl(1'b1, 1'b1);
    waitCycles(4);
    outEn = 1'b1;
    waitCycles(3);
    checkOut(8'h0F, "R8 re-enable shows register");
  endtask

  task automatic testMidReset();
    setCtrl(1'b0, 1'b1);
    dataIn = 8'h99;
    waitCycles(4);
    rstN = 1'b0;
    #1;
    checkOut(8'h00, "R7 async reset");
    setCtrl(1'b1, 1'b1);
    @(negedge clk);
    rstN = 1'b1;
    waitCycles(4);
    setCtrl(1'b1, 1'b0);
    waitCycles(4);
    syncN = 1'b1;
    waitCycles(4);
    checkOut(8'h00, "R7 buffers cleared by reset");
  endtask

  initial begin
    testReset();
    testDirect();
    testHold();
    testSyncPath();
    testEnable();
    testMidReset();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule